// File: doc/BRIEF.md
# AXI Address-Channel Burst Formatter

This block sits between the internal memory-request logic of a processor and the address channels of a 64-bit AXI master port. A requester presents one access at a time. Each access has a start address, a byte count, a kind (data, instruction fetch or cache linefill), a direction, and attributes: cacheable, shared, exclusive and locked. The block turns the access into one or more read-address or write-address commands with address, burst type, beat size and burst length. Every command it emits obeys a fixed rule set for the port.

A linefill to cacheable memory that is not shared becomes a single wrapping read of four 64-bit beats. Any other access becomes incrementing bursts. These are cut wherever the access would leave an aligned 32-byte region, and they are issued in ascending address order. Narrow beats (8 or 16 bits) always go out one beat per command. Write commands are held back until every data beat of the previous write burst has been reported. This keeps write data from separate bursts from interleaving. The requester learns that its access is complete from a one-cycle acknowledge, which is given in the cycle the last command is accepted.

Top module: `axi_burst_fmt`

## Requirements
- R1: No emitted command moves more than 32 bytes or has more than 8 beats ((LEN+1) << SIZE <= 32, LEN <= 7).
- R2: Incrementing commands never cross an aligned 32-byte boundary. The pieces of one access are issued in ascending address order, each piece starting where the previous one ended, until every beat of the access is covered.
- R3: Burst type encodings are FIXED=2'b00, INCR=2'b01 and WRAP=2'b10. FIXED never appears, and the write-address channel only ever carries INCR.
- R4: A linefill (kind 2'd2) with cacheable set and shared clear produces one read command: WRAP, SIZE 3, LEN 3, with the address's low three bits cleared.
- R5: A linefill that is not cacheable, or is shared, produces one INCR read command of SIZE 3 and LEN 3 at the address with its low five bits cleared.
- R6: When SIZE is 0 or 1 (8 or 16-bit beats), every command has LEN 0.
- R7: SIZE is log2 of the bytes per beat and is clamped to 3 when the requested size code exceeds 3. LEN is the beat count minus one. A data access (kind 0 or 3) covers ceil((addr mod B + bytes) / B) beats of B = 2^SIZE bytes, starting at the address with its low SIZE bits cleared. The byte-count input carries the byte count minus one.
- R8: An instruction fetch (kind 2'd1) always uses SIZE 3 and protection 3'b100, carries lock 2'b00, and is a read even when the write input is set.
- R9: Lock encoding is 2'b10 for locked and 2'b01 for exclusive, and locked wins when both are set. Only data accesses carry a lock, and a locked or exclusive command's address is aligned to its beat size.
- R10: A command that is valid but not yet accepted stays valid with the same address and length. The requester acknowledge pulses for exactly one cycle, in the cycle the last command of the access is accepted, and no command is offered in the cycle after it.
- R11: A write-address command is offered only after the data-beat input has counted every beat of the previous write command. The last-beat output is high while exactly one beat of the current write burst remains.
- R12: While reset is asserted, neither address channel is valid and the acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Access complete; pulses with the last command handshake |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Byte count minus one |
| req_size_i | input | 3 | Requested beat size code for data accesses |
| req_kind_i | input | 2 | 0 or 3 data, 1 instruction fetch, 2 linefill |
| req_write_i | input | 1 | Data access is a write |
| req_cacheable_i | input | 1 | Target is cacheable |
| req_shared_i | input | 1 | Target is shared |
| req_excl_i | input | 1 | Exclusive access |
| req_locked_i | input | 1 | Locked access |
| ar_valid_o | output | 1 | Read command valid |
| ar_ready_i | input | 1 | Read command accepted |
| ar_addr_o | output | ADDR_W | Read command address |
| ar_burst_o | output | 2 | Read burst type |
| ar_size_o | output | 3 | Read beat size |
| ar_len_o | output | 8 | Read beats minus one |
| ar_lock_o | output | 2 | Read lock type |
| ar_prot_o | output | 3 | Read protection, bit 2 marks instruction fetch |
| aw_valid_o | output | 1 | Write command valid |
| aw_ready_i | input | 1 | Write command accepted |
| aw_addr_o | output | ADDR_W | Write command address |
| aw_burst_o | output | 2 | Write burst type |
| aw_size_o | output | 3 | Write beat size |
| aw_len_o | output | 8 | Write beats minus one |
| aw_lock_o | output | 2 | Write lock type |
| aw_prot_o | output | 3 | Write protection |
| w_beat_i | input | 1 | One write data beat transferred |
| w_last_o | output | 1 | Current write data beat is the burst's last |

## Verification
The bench sweeps start offsets across and past a 32-byte boundary, for every size code including the out-of-range ones and for byte counts from one to several regions. It goes after the piece that ends exactly on a boundary: a formatter that computed the room left in the region with an off-by-one would emit a command that crosses the boundary, or one that is a beat short, and would then skip or repeat a beat address. It offers linefills at every offset with all four cacheable and shared combinations, so that a wrap issued for shared memory, or a wrap not aligned to 8 bytes, shows up as a wrong burst type or address. Both ready signals and the write-beat reports stall pseudo-randomly. A design that dropped the acknowledge early, changed an unaccepted command, or issued a write address while data was still owed would show up as a wrong acknowledge, a changed command or a write command offered too early.

// File: rtl/axf_pkg.sv
package axf_pkg;
  localparam logic [1:0] KIND_IFETCH = 2'd1;
  localparam logic [1:0] KIND_LINE   = 2'd2;
  localparam int NARROW_SIZE_LIM     = 2;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10
  } burst_e;

  typedef struct packed {
    logic       wrap;
    logic       write;
    logic [1:0] lock;
    logic [2:0] prot;
    logic [2:0] size;
  } xattr_t;
endpackage

// File: rtl/axf_decode.sv
module axf_decode import axf_pkg::*; #(
  parameter int ADDR_W       = 32,
  parameter int LEN_W        = 8,
  parameter int BUS_BYTES    = 8,
  parameter int REGION_BYTES = 32,
  parameter int BEAT_W       = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        kind_i,
  input  logic              write_i,
  input  logic              cacheable_i,
  input  logic              shared_i,
  input  logic              excl_i,
  input  logic              locked_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [BEAT_W-1:0] beats_o,
  output xattr_t            attr_o
);
  localparam int LOG_BUS    = $clog2(BUS_BYTES);
  localparam int LOG_REG    = $clog2(REGION_BYTES);
  localparam int LINE_BEATS = REGION_BYTES / BUS_BYTES;

  logic [2:0]         size_c;
  logic [LOG_BUS-1:0] lo_mask;
  logic [LOG_BUS-1:0] offs;
  logic [BEAT_W-1:0]  span;

  always_comb begin
    size_c  = (kind_i == KIND_IFETCH || size_i > 3'(LOG_BUS)) ? 3'(LOG_BUS) : size_i;
    lo_mask = ~({LOG_BUS{1'b1}} << size_c);
    offs    = addr_i[LOG_BUS-1:0] & lo_mask;
    // offset + bytes, rounded up to whole beats
    span    = BEAT_W'(offs) + BEAT_W'(len_i) + BEAT_W'(lo_mask) + BEAT_W'(1);
    attr_o  = '0;
    if (kind_i == KIND_LINE) begin
      attr_o.wrap = cacheable_i & ~shared_i;
      attr_o.size = 3'(LOG_BUS);
      base_o      = attr_o.wrap ? {addr_i[ADDR_W-1:LOG_BUS], LOG_BUS'(0)}
                                : {addr_i[ADDR_W-1:LOG_REG], LOG_REG'(0)};
      beats_o     = BEAT_W'(LINE_BEATS);
    end else begin
      attr_o.size  = size_c;
      attr_o.write = write_i & (kind_i != KIND_IFETCH);
      attr_o.prot  = (kind_i == KIND_IFETCH) ? 3'b100 : 3'b000;
      if (kind_i != KIND_IFETCH)
        attr_o.lock = locked_i ? 2'b10 : (excl_i ? 2'b01 : 2'b00);
      base_o  = {addr_i[ADDR_W-1:LOG_BUS], addr_i[LOG_BUS-1:0] & ~lo_mask};
      beats_o = span >> size_c;
    end
  end
endmodule

// File: rtl/axf_split.sv
module axf_split import axf_pkg::*; #(
  parameter int BUS_BYTES    = 8,
  parameter int REGION_BYTES = 32,
  parameter int MAX_BEATS    = 8,
  parameter int BEAT_W       = 12,
  parameter int NB_W         = 4
) (
  input  logic [$clog2(REGION_BYTES)-1:0] offs_i,
  input  logic [BEAT_W-1:0]               rem_i,
  input  logic [2:0]                      size_i,
  input  logic                            wrap_i,
  output logic [NB_W-1:0]                 n_o,
  output logic                            last_o
);
  localparam int LOG_REG    = $clog2(REGION_BYTES);
  localparam int LINE_BEATS = REGION_BYTES / BUS_BYTES;

  logic [LOG_REG:0]  room_bytes;
  logic [LOG_REG:0]  room;
  logic [LOG_REG:0]  cap;
  logic [BEAT_W-1:0] cap_w;

  always_comb begin
    room_bytes = (LOG_REG+1)'(REGION_BYTES) - {1'b0, offs_i};
    room       = room_bytes >> size_i;
    if (wrap_i)                              cap = (LOG_REG+1)'(LINE_BEATS);
    else if (int'(size_i) < NARROW_SIZE_LIM) cap = (LOG_REG+1)'(1);
    else if (int'(room) > MAX_BEATS)         cap = (LOG_REG+1)'(MAX_BEATS);
    else                                     cap = room;
    cap_w  = BEAT_W'(cap);
    last_o = rem_i <= cap_w;
    n_o    = last_o ? NB_W'(rem_i) : NB_W'(cap);
  end
endmodule

// File: rtl/axf_wr_order.sv
module axf_wr_order #(
  parameter int NB_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            aw_hs_i,
  input  logic [NB_W-1:0] aw_beats_i,
  input  logic            w_beat_i,
  output logic            free_o,
  output logic            w_last_o
);
  logic [NB_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         left_q <= '0;
    else if (aw_hs_i)                    left_q <= aw_beats_i;
    else if (w_beat_i && left_q != '0)   left_q <= left_q - NB_W'(1);
  end

  assign free_o   = (left_q == '0);
  assign w_last_o = (left_q == NB_W'(1));

  AST_AW_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni) aw_hs_i |-> left_q == '0); // R11
endmodule

// File: rtl/axi_burst_fmt.sv
module axi_burst_fmt import axf_pkg::*; #(
  parameter int ADDR_W       = 32,
  parameter int LEN_W        = 8,
  parameter int BUS_BYTES    = 8,
  parameter int REGION_BYTES = 32,
  parameter int MAX_BEATS    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [2:0]        req_size_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_write_i,
  input  logic              req_cacheable_i,
  input  logic              req_shared_i,
  input  logic              req_excl_i,
  input  logic              req_locked_i,
  output logic              ar_valid_o,
  input  logic              ar_ready_i,
  output logic [ADDR_W-1:0] ar_addr_o,
  output logic [1:0]        ar_burst_o,
  output logic [2:0]        ar_size_o,
  output logic [7:0]        ar_len_o,
  output logic [1:0]        ar_lock_o,
  output logic [2:0]        ar_prot_o,
  output logic              aw_valid_o,
  input  logic              aw_ready_i,
  output logic [ADDR_W-1:0] aw_addr_o,
  output logic [1:0]        aw_burst_o,
  output logic [2:0]        aw_size_o,
  output logic [7:0]        aw_len_o,
  output logic [1:0]        aw_lock_o,
  output logic [2:0]        aw_prot_o,
  input  logic              w_beat_i,
  output logic              w_last_o
);
  localparam int LOG_BUS = $clog2(BUS_BYTES);
  localparam int LOG_REG = $clog2(REGION_BYTES);
  localparam int BEAT_W  = LEN_W + LOG_BUS + 1;
  localparam int NB_W    = $clog2(MAX_BEATS + 1);

  logic              busy_q;
  logic [ADDR_W-1:0] cur_q;
  logic [BEAT_W-1:0] rem_q;
  xattr_t            attr_q;

  logic [ADDR_W-1:0] dec_base;
  logic [BEAT_W-1:0] dec_beats;
  xattr_t            dec_attr;
  logic [NB_W-1:0]   n;
  logic              last, hs, wr_free;

  axf_decode #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES),
    .REGION_BYTES(REGION_BYTES), .BEAT_W(BEAT_W)
  ) u_decode (
    .addr_i(req_addr_i), .len_i(req_len_i), .size_i(req_size_i), .kind_i(req_kind_i),
    .write_i(req_write_i), .cacheable_i(req_cacheable_i), .shared_i(req_shared_i),
    .excl_i(req_excl_i), .locked_i(req_locked_i),
    .base_o(dec_base), .beats_o(dec_beats), .attr_o(dec_attr)
  );

  axf_split #(
    .BUS_BYTES(BUS_BYTES), .REGION_BYTES(REGION_BYTES), .MAX_BEATS(MAX_BEATS),
    .BEAT_W(BEAT_W), .NB_W(NB_W)
  ) u_split (
    .offs_i(cur_q[LOG_REG-1:0]), .rem_i(rem_q), .size_i(attr_q.size), .wrap_i(attr_q.wrap),
    .n_o(n), .last_o(last)
  );

  axf_wr_order #(.NB_W(NB_W)) u_wr_order (
    .clk_i(clk_i), .rst_ni(rst_ni), .aw_hs_i(aw_valid_o & aw_ready_i),
    .aw_beats_i(n), .w_beat_i(w_beat_i), .free_o(wr_free), .w_last_o(w_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      rem_q  <= '0;
      attr_q <= '0;
    end else if (!busy_q) begin
      if (req_valid_i) begin
        busy_q <= 1'b1;
        cur_q  <= dec_base;
        rem_q  <= dec_beats;
        attr_q <= dec_attr;
      end
    end else if (hs) begin
      cur_q <= cur_q + (ADDR_W'(n) << attr_q.size);
      rem_q <= rem_q - BEAT_W'(n);
      if (last) busy_q <= 1'b0;
    end
  end

  assign ar_valid_o  = busy_q & ~attr_q.write;
  assign aw_valid_o  = busy_q & attr_q.write & wr_free;
  assign hs          = (ar_valid_o & ar_ready_i) | (aw_valid_o & aw_ready_i);
  assign req_ready_o = hs & last;

  assign ar_addr_o  = cur_q;
  assign ar_burst_o = attr_q.wrap ? BURST_WRAP : BURST_INCR;
  assign ar_size_o  = attr_q.size;
  assign ar_len_o   = 8'(n) - 8'd1;
  assign ar_lock_o  = attr_q.lock;
  assign ar_prot_o  = attr_q.prot;
  assign aw_addr_o  = cur_q;
  assign aw_burst_o = BURST_INCR;
  assign aw_size_o  = attr_q.size;
  assign aw_len_o   = 8'(n) - 8'd1;
  assign aw_lock_o  = attr_q.lock;
  assign aw_prot_o  = attr_q.prot;

  AST_AR_MAX_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni) ar_valid_o |-> ar_len_o <= 8'(MAX_BEATS-1) && ((int'(ar_len_o) + 1) << ar_size_o) <= REGION_BYTES); // R1
  AST_AW_MAX_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni) aw_valid_o |-> aw_len_o <= 8'(MAX_BEATS-1) && ((int'(aw_len_o) + 1) << aw_size_o) <= REGION_BYTES); // R1
  AST_AR_NO_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni) (ar_valid_o && ar_burst_o == BURST_INCR) |-> int'(ar_addr_o[LOG_REG-1:0]) + ((int'(ar_len_o) + 1) << ar_size_o) <= REGION_BYTES); // R2
  AST_AW_NO_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni) aw_valid_o |-> int'(aw_addr_o[LOG_REG-1:0]) + ((int'(aw_len_o) + 1) << aw_size_o) <= REGION_BYTES); // R2
  AST_NO_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni) (ar_valid_o |-> ar_burst_o != BURST_FIXED) and (aw_valid_o |-> aw_burst_o == BURST_INCR)); // R3
  AST_WRAP_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni) (ar_valid_o && ar_burst_o == BURST_WRAP) |-> ar_size_o == 3'(LOG_BUS) && ar_len_o == 8'd3 && ar_addr_o[LOG_BUS-1:0] == '0); // R4
  AST_NARROW_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) ((ar_valid_o && int'(ar_size_o) < NARROW_SIZE_LIM) |-> ar_len_o == 8'd0) and ((aw_valid_o && int'(aw_size_o) < NARROW_SIZE_LIM) |-> aw_len_o == 8'd0)); // R6
  AST_SIZE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni) (ar_valid_o |-> ar_size_o <= 3'(LOG_BUS)) and (aw_valid_o |-> aw_size_o <= 3'(LOG_BUS))); // R7
  AST_IFETCH_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni) (ar_valid_o && ar_prot_o[2]) |-> ar_size_o == 3'(LOG_BUS) && ar_lock_o == 2'b00); // R8
  AST_LOCK_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni) (ar_valid_o && ar_lock_o != 2'b00) |-> (ar_addr_o[LOG_BUS-1:0] & ~({LOG_BUS{1'b1}} << ar_size_o)) == '0); // R9
  AST_AR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (ar_valid_o && !ar_ready_i) |=> ar_valid_o && $stable(ar_addr_o) && $stable(ar_len_o)); // R10
  AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) req_ready_o |=> !ar_valid_o && !aw_valid_o); // R10
endmodule

// File: tb/tb_axi_burst_fmt.sv
module tb_axi_burst_fmt;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_kind = '0;
  logic        req_write = 1'b0, req_cach = 1'b0, req_shr = 1'b0, req_ex = 1'b0, req_lk = 1'b0;
  logic        ar_valid, ar_ready = 1'b0, aw_valid, aw_ready = 1'b0;
  logic [31:0] ar_addr, aw_addr;
  logic [1:0]  ar_burst, aw_burst, ar_lock, aw_lock;
  logic [2:0]  ar_size, aw_size, ar_prot, aw_prot;
  logic [7:0]  ar_len, aw_len;
  logic        w_beat = 1'b0, w_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_burst_fmt dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_size_i(req_size), .req_kind_i(req_kind),
    .req_write_i(req_write), .req_cacheable_i(req_cach), .req_shared_i(req_shr),
    .req_excl_i(req_ex), .req_locked_i(req_lk),
    .ar_valid_o(ar_valid), .ar_ready_i(ar_ready), .ar_addr_o(ar_addr), .ar_burst_o(ar_burst),
    .ar_size_o(ar_size), .ar_len_o(ar_len), .ar_lock_o(ar_lock), .ar_prot_o(ar_prot),
    .aw_valid_o(aw_valid), .aw_ready_i(aw_ready), .aw_addr_o(aw_addr), .aw_burst_o(aw_burst),
    .aw_size_o(aw_size), .aw_len_o(aw_len), .aw_lock_o(aw_lock), .aw_prot_o(aw_prot),
    .w_beat_i(w_beat), .w_last_o(w_last)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model of the access in flight
  bit          m_active = 0, m_wrap, m_write;
  int          m_kind, m_size, m_rem;
  logic [31:0] m_addr;
  logic [1:0]  m_lock;
  logic [2:0]  m_prot;
  int          owed = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_cap();
    int room;
    room = (32 - int'(m_addr % 32)) >> m_size;
    if (m_wrap) return 4;
    if (m_size < 2) return 1;
    return (room > 8) ? 8 : room;
  endfunction

  function automatic string tag_for(input int cap);
    if (m_kind == 2) return m_wrap ? "R4" : "R5";
    if (m_kind == 1) return "R8";
    if (m_size < 2) return "R6";
    if (cap < m_rem) return "R2";
    return "R7";
  endfunction

  task automatic check_txn(input bit is_w, input logic [31:0] a, input logic [1:0] b, input logic [2:0] s,
                           input logic [7:0] l, input logic [1:0] lk, input logic [2:0] p);
    int cap, n;
    string t;
    if (!m_active) begin
      chk(0, "R10", "command with no access pending", 1, 0);
      return;
    end
    cap = exp_cap();
    n = (m_rem < cap) ? m_rem : cap;
    t = tag_for(cap);
    chk(is_w == m_write, t, "channel", is_w, m_write);
    chk(a == m_addr, t, "addr", a, m_addr);
    chk(int'(l) == n - 1, t, "len", l, n - 1);
    chk(int'(s) == m_size, t, "size", s, m_size);
    chk(b == (m_wrap ? 2'b10 : 2'b01), t, "burst", b, m_wrap ? 2 : 1);
    chk(lk == m_lock, "R9", "lock", lk, m_lock);
    chk(p == m_prot, "R8", "prot", p, m_prot);
    chk(int'(l) <= 7 && ((int'(l) + 1) << s) <= 32, "R1", "bytes per command", (int'(l) + 1) << s, 32);
    chk(b != 2'b00 && (!is_w || b == 2'b01), "R3", "burst kind", b, 1);
    m_addr = m_addr + (32'(n) << m_size);
    m_rem  = m_rem - n;
    chk(req_ready == (m_rem == 0), "R10", "ack on last command", req_ready, m_rem == 0);
    if (m_rem == 0) m_active = 0;
    if (is_w) owed = owed + n;
  endtask

  bit          p_ar_stall = 0, p_aw_stall = 0;
  logic [31:0] p_ar_addr, p_aw_addr;
  logic [7:0]  p_ar_len, p_aw_len;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ar_stall) chk(ar_valid && ar_addr == p_ar_addr && ar_len == p_ar_len, "R10", "ar held", ar_addr, p_ar_addr);
      if (p_aw_stall) chk(aw_valid && aw_addr == p_aw_addr && aw_len == p_aw_len, "R10", "aw held", aw_addr, p_aw_addr);
      p_ar_stall = ar_valid && !ar_ready; p_ar_addr = ar_addr; p_ar_len = ar_len;
      p_aw_stall = aw_valid && !aw_ready; p_aw_addr = aw_addr; p_aw_len = aw_len;
      if (w_beat) begin
        chk(w_last == (owed == 1), "R11", "w_last", w_last, owed == 1);
        owed = owed - 1;
      end
      if (aw_valid) chk(owed == 0, "R11", "aw offered with data owed", owed, 0);
      if (req_ready && !(ar_valid && ar_ready) && !(aw_valid && aw_ready))
        chk(0, "R10", "ack without handshake", 1, 0);
      if (ar_valid && ar_ready) check_txn(0, ar_addr, ar_burst, ar_size, ar_len, ar_lock, ar_prot);
      if (aw_valid && aw_ready) check_txn(1, aw_addr, aw_burst, aw_size, aw_len, aw_lock, aw_prot);
    end
  end

  // pseudo-random ready and write-beat stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ar_ready = lfsr[0] | lfsr[3];
      aw_ready = lfsr[1] | lfsr[5];
      w_beat   = (owed > 0) && (lfsr[2] | lfsr[7]);
    end
  end

  task automatic run_req(input logic [1:0] kind, input logic [31:0] addr, input int len, input int size,
                         input bit wr, input bit cach, input bit shr, input bit ex, input bit lk);
    int s, bb, offs;
    m_kind = kind;
    if (kind == 2) begin
      m_size = 3; m_rem = 4; m_write = 0; m_lock = 2'b00; m_prot = 3'b000;
      m_wrap = cach && !shr;
      m_addr = m_wrap ? (addr & ~32'd7) : (addr & ~32'd31);
    end else begin
      s = (kind == 1 || size > 3) ? 3 : size;
      bb = 1 << s;
      offs = int'(addr % 32'(bb));
      m_size = s; m_wrap = 0;
      m_addr = addr - 32'(offs);
      m_rem = (offs + len + 1 + bb - 1) / bb;
      m_write = (kind == 1) ? 0 : wr;
      m_lock = (kind == 1) ? 2'b00 : (lk ? 2'b10 : (ex ? 2'b01 : 2'b00));
      m_prot = (kind == 1) ? 3'b100 : 3'b000;
    end
    m_active = 1;
    req_kind = kind; req_addr = addr; req_len = 8'(len); req_size = 3'(size);
    req_write = wr; req_cach = cach; req_shr = shr; req_ex = ex; req_lk = lk;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!m_active, "R10", "access fully issued", m_rem, 0);
    chk(!ar_valid && !aw_valid, "R10", "idle after ack", {ar_valid, aw_valid}, 0);
    @(posedge clk);
    #1;
  endtask

  initial begin
    int lens[6] = '{0, 1, 5, 8, 23, 40};
    int wlens[3] = '{0, 7, 31};
    int ilens[3] = '{3, 31, 63};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ar_valid && !aw_valid && !req_ready, "R12", "reset outputs", {ar_valid, aw_valid, req_ready}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // data reads, every size code including clamped ones (R2 R6 R7 R9)
    for (int sz = 0; sz < 5; sz++)
      for (int o = 0; o < 36; o++)
        for (int li = 0; li < 6; li++)
          run_req(2'd0, 32'h1000_0000 + 32'(o), lens[li], sz, 0, 0, 0, (o % 3) == 1, (o % 5) == 2);
    // data writes, kind 3 treated as data (R11 R3)
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 34; o++)
        for (int li = 0; li < 3; li++)
          run_req((o % 2) ? 2'd3 : 2'd0, 32'h2000_0040 + 32'(o), wlens[li], sz, 1, 1, 0, (o % 3) == 0, (o % 4) == 0);
    // instruction fetches with write and lock inputs set (R8)
    for (int o = 0; o < 41; o++)
      for (int li = 0; li < 3; li++)
        run_req(2'd1, 32'h0000_3000 + 32'(o), ilens[li], o % 8, 1, 1, 0, 1, (o % 2) == 1);
    // linefills at every offset, all attribute combinations (R4 R5)
    for (int o = 0; o < 64; o++)
      for (int c = 0; c < 4; c++)
        run_req(2'd2, 32'h4000_0100 + 32'(o), 5, 0, (c % 2) == 1, c[0], c[1], 1, 0);
    while (owed != 0) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog act=%0d exp=%0d", WD_CYCLES, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule